// File: doc/BRIEF.md
# Working Register Pointer Translator

This block keeps two pointer registers and maps a 4-bit working-register number (r0 to r15) onto an 8-bit register-file address. The register file is split into 32 blocks of eight registers. Each pointer register names one of those blocks through a 5-bit group field. A flag in the first pointer selects how the working registers are spread over the blocks.

In single mode, the sixteen working registers fill two neighbouring blocks, starting at the group held in the first pointer. In twin mode, r0 to r7 fall in the block named by the first pointer, and r8 to r15 fall in the block named by the second pointer. The two pointers can be set independently.

Three set-pointer commands load the pointers. Each command carries a 5-bit group operand, and each one sets or clears the mode flag as a side effect. A plain bus port can also write either pointer register, and both registers can be read back at all times. The translated address is combinational from the stored pointers and the working-register number.

Top module: `wrp_translator`

## Requirements
- R1: After a synchronous reset both pointer read values are 8'h00. The block is then in single mode with group 0, so the address equals the working-register number.
- R2: Each pointer register holds its group in bits 7:3 and the twin-mode flag in bit 2. Bits 1:0 always read as 0, including after a bus write that sets them to 1.
- R3: A valid command with op 0 (single) loads the first pointer with {grp, 0, 00} and the second pointer with {grp+1 mod 32, 0, 00}. The new values are visible from the cycle after the command.
- R4: A valid command with op 1 (twin low) loads the first pointer's group with grp and leaves the second pointer's group unchanged. It sets bit 2 in both pointers.
- R5: A valid command with op 2 (twin high) loads the second pointer's group with grp and leaves the first pointer's group unchanged. It sets bit 2 in both pointers.
- R6: A command with op 3, or any op presented while cmd_valid is low, leaves both pointer registers unchanged.
- R7: In single mode the address is (first group × 8 + working-register number) mod 256. At group 31 this wraps, so r8 maps to address 0.
- R8: In twin mode, r0 to r7 map to first group × 8 + n[2:0], and r8 to r15 map to second group × 8 + n[2:0].
- R9: The mode used for translation is bit 2 of the first pointer only. Bit 2 of the second pointer has no effect on the address.
- R10: A bus write with bus_wr_sel = 0 (first pointer) or 1 (second pointer) loads bits 7:2 of the selected register from the write data on the next cycle. The other register is unchanged.
- R11: When a valid command with op 0 to 2 and a bus write occur in the same cycle, only the command takes effect and the bus write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Set-pointer command strobe |
| cmd_op | input | 2 | Command kind: 0 single, 1 twin low, 2 twin high, 3 none |
| cmd_grp | input | 5 | Group operand of the command |
| bus_wr_en | input | 1 | Pointer register write strobe |
| bus_wr_sel | input | 1 | Target of the write: 0 first pointer, 1 second pointer |
| bus_wr_data | input | 8 | Write data |
| wreg | input | 4 | Working-register number to translate |
| addr | output | 8 | Translated register-file address |
| ptr0_q | output | 8 | Read value of the first pointer |
| ptr1_q | output | 8 | Read value of the second pointer |

## Verification
Commands and bus writes are registered, so they show in ptr0_q, ptr1_q and addr one clock edge after the cycle in which they are presented. The address has no register of its own and follows a change of wreg within the same cycle. The bench drives every input on a falling edge. It samples pointer values on the next falling edge, which lies after exactly one rising edge. For address sweeps it changes wreg and checks addr a nanosecond later, with no clock edge in between.

// File: rtl/wrp_pkg.sv
package wrp_pkg;

    // Width of the group field in a pointer register.
    localparam int GRP_W  = 5;
    // log2 of the number of registers in one block.
    localparam int BLK_W  = 3;
    // Width of the working-register number.
    localparam int WR_W   = BLK_W + 1;
    // Width of the register-file address.
    localparam int ADDR_W = GRP_W + BLK_W;
    // Number of always-zero low bits in a pointer register.
    localparam int RSV_W  = 2;
    // Width of a whole pointer register.
    localparam int PTR_W  = GRP_W + 1 + RSV_W;
    // Number of pointer registers.
    localparam int NPTR   = 2;

    typedef enum logic [1:0] {
        OP_SINGLE  = 2'd0,
        OP_TWIN_LO = 2'd1,
        OP_TWIN_HI = 2'd2,
        OP_NONE    = 2'd3
    } op_e;

    typedef struct packed {
        logic [GRP_W-1:0] grp;
        logic             twin;
        logic [RSV_W-1:0] rsv;
    } ptr_t;

    // Builds a pointer value with the reserved bits cleared.
    function automatic ptr_t make_ptr(logic [GRP_W-1:0] g, logic twin);
        ptr_t p;
        p.grp  = g;
        p.twin = twin;
        p.rsv  = '0;
        return p;
    endfunction

    // First register-file address of a block.
    function automatic logic [ADDR_W-1:0] blk_base(logic [GRP_W-1:0] g);
        return {g, {BLK_W{1'b0}}};
    endfunction

endpackage

// File: rtl/wrp_cmd_dec.sv
module wrp_cmd_dec
    import wrp_pkg::*;
(
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [GRP_W-1:0]     cmd_grp,
    input  logic                 bus_wr_en,
    input  logic                 bus_wr_sel,
    input  logic [PTR_W-1:0]     bus_wr_data,
    input  ptr_t                 cur  [NPTR],
    output ptr_t                 nxt  [NPTR],
    output logic [NPTR-1:0]      ld
);

    op_e              op;
    logic             cmd_act;
    logic [GRP_W-1:0] grp_up;

    assign op      = op_e'(cmd_op);
    assign cmd_act = cmd_valid && (op != OP_NONE);
    assign grp_up  = cmd_grp + GRP_W'(1);

    always_comb begin
        nxt[0] = cur[0];
        nxt[1] = cur[1];
        ld     = '0;
        if (cmd_act) begin
            ld = '1;
            unique case (op)
                OP_SINGLE: begin
                    nxt[0] = make_ptr(cmd_grp, 1'b0);
                    nxt[1] = make_ptr(grp_up, 1'b0);
                end
                OP_TWIN_LO: begin
                    nxt[0] = make_ptr(cmd_grp, 1'b1);
                    nxt[1] = make_ptr(cur[1].grp, 1'b1);
                end
                OP_TWIN_HI: begin
                    nxt[0] = make_ptr(cur[0].grp, 1'b1);
                    nxt[1] = make_ptr(cmd_grp, 1'b1);
                end
                default: ld = '0;
            endcase
        end else if (bus_wr_en) begin
            if (bus_wr_sel) begin
                nxt[1] = ptr_t'(bus_wr_data);
                ld[1]  = 1'b1;
            end else begin
                nxt[0] = ptr_t'(bus_wr_data);
                ld[0]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wrp_ptr_reg.sv
module wrp_ptr_reg
    import wrp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  ptr_t d,
    output ptr_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= make_ptr('0, 1'b0);
        end else if (ld) begin
            q <= make_ptr(d.grp, d.twin);
        end
    end

endmodule

// File: rtl/wrp_xlate.sv
module wrp_xlate
    import wrp_pkg::*;
(
    input  ptr_t               p0,
    input  ptr_t               p1,
    input  logic [WR_W-1:0]    wreg,
    output logic [ADDR_W-1:0]  addr
);

    logic [GRP_W-1:0] twin_grp;

    assign twin_grp = wreg[WR_W-1] ? p1.grp : p0.grp;

    always_comb begin
        if (p0.twin) begin
            addr = blk_base(twin_grp) + ADDR_W'(wreg[BLK_W-1:0]);
        end else begin
            addr = blk_base(p0.grp) + ADDR_W'(wreg);
        end
    end

endmodule

// File: rtl/wrp_translator.sv
module wrp_translator
    import wrp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    input  logic [GRP_W-1:0]      cmd_grp,
    input  logic                  bus_wr_en,
    input  logic                  bus_wr_sel,
    input  logic [PTR_W-1:0]      bus_wr_data,
    input  logic [WR_W-1:0]       wreg,
    output logic [ADDR_W-1:0]     addr,
    output logic [PTR_W-1:0]      ptr0_q,
    output logic [PTR_W-1:0]      ptr1_q
);

    ptr_t            cur [NPTR];
    ptr_t            nxt [NPTR];
    logic [NPTR-1:0] ld;

    wrp_cmd_dec u_dec (
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_grp     (cmd_grp),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_sel  (bus_wr_sel),
        .bus_wr_data (bus_wr_data),
        .cur         (cur),
        .nxt         (nxt),
        .ld          (ld)
    );

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        wrp_ptr_reg u_reg (
            .clk (clk),
            .rst (rst),
            .ld  (ld[i]),
            .d   (nxt[i]),
            .q   (cur[i])
        );
    end

    wrp_xlate u_xl (
        .p0   (cur[0]),
        .p1   (cur[1]),
        .wreg (wreg),
        .addr (addr)
    );

    assign ptr0_q = cur[0];
    assign ptr1_q = cur[1];

endmodule

// File: rtl/wrp_translator_chk.sv
module wrp_translator_chk
    import wrp_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_valid,
    input logic [1:0]           cmd_op,
    input logic [GRP_W-1:0]     cmd_grp,
    input logic                 bus_wr_en,
    input logic                 bus_wr_sel,
    input logic [PTR_W-1:0]     bus_wr_data,
    input logic [WR_W-1:0]      wreg,
    input logic [ADDR_W-1:0]    addr,
    input logic [PTR_W-1:0]     ptr0_q,
    input logic [PTR_W-1:0]     ptr1_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ptr0_q == '0 && ptr1_q == '0));

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr0_q[1:0] == 2'b00 && ptr1_q[1:0] == 2'b00));

    // R3
    single_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd0) |=>
        (ptr0_q == {$past(cmd_grp), 3'b000} &&
         ptr1_q == {GRP_W'($past(cmd_grp) + GRP_W'(1)), 3'b000}));

    // R4
    twin_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd1) |=>
        (ptr0_q[7:3] == $past(cmd_grp) && ptr1_q[7:3] == $past(ptr1_q[7:3]) &&
         ptr0_q[2] && ptr1_q[2]));

    // R5
    twin_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd2) |=>
        (ptr1_q[7:3] == $past(cmd_grp) && ptr0_q[7:3] == $past(ptr0_q[7:3]) &&
         ptr0_q[2] && ptr1_q[2]));

    // R6
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ((!cmd_valid || cmd_op == 2'd3) && !bus_wr_en) |=>
        ($stable(ptr0_q) && $stable(ptr1_q)));

    // R8
    twin_low_half_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr0_q[2] && !wreg[3]) |->
        (addr[7:3] == ptr0_q[7:3] && addr[2:0] == wreg[2:0]));

    // R8
    twin_high_half_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr0_q[2] && wreg[3]) |->
        (addr[7:3] == ptr1_q[7:3] && addr[2:0] == wreg[2:0]));

    // R10
    bus_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && !(cmd_valid && cmd_op != 2'd3) && !bus_wr_sel) |=>
        (ptr0_q[7:2] == $past(bus_wr_data[7:2]) && $stable(ptr1_q)));

endmodule

bind wrp_translator wrp_translator_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_grp     (cmd_grp),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_sel  (bus_wr_sel),
    .bus_wr_data (bus_wr_data),
    .wreg        (wreg),
    .addr        (addr),
    .ptr0_q      (ptr0_q),
    .ptr1_q      (ptr1_q)
);

// File: tb/tb_wrp_translator.sv
module tb_wrp_translator;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd3;
    logic [4:0] cmd_grp = '0;
    logic       bus_wr_en = 1'b0;
    logic       bus_wr_sel = 1'b0;
    logic [7:0] bus_wr_data = '0;
    logic [3:0] wreg = '0;
    logic [7:0] addr;
    logic [7:0] ptr0_q;
    logic [7:0] ptr1_q;

    int checks = 0;
    int errors = 0;

    // Model of the two pointer registers.
    logic [7:0] m0 = '0;
    logic [7:0] m1 = '0;

    always #10 clk = ~clk;

    wrp_translator dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_grp(cmd_grp), .bus_wr_en(bus_wr_en), .bus_wr_sel(bus_wr_sel),
        .bus_wr_data(bus_wr_data), .wreg(wreg), .addr(addr),
        .ptr0_q(ptr0_q), .ptr1_q(ptr1_q)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_addr(input logic [3:0] w);
        if (m0[2]) begin
            return w[3] ? {m1[7:3], w[2:0]} : {m0[7:3], w[2:0]};
        end
        return 8'({m0[7:3], 3'b000} + {4'b0000, w});
    endfunction

    // Presents a command for one cycle; registers are sampled one edge later.
    task automatic do_cmd(input logic [1:0] op, input logic [4:0] g);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_grp = g;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd3;
    endtask

    task automatic do_wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_wr_sel = sel; bus_wr_data = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic check_regs(input string req);
        chk({req, " ptr0"}, ptr0_q, m0);
        chk({req, " ptr1"}, ptr1_q, m1);
    endtask

    task automatic check_all_addr(input string req);
        for (int w = 0; w < 16; w++) begin
            wreg = 4'(w);
            #1;
            chk(req, addr, ref_addr(4'(w)));
        end
    endtask

    task automatic t_reset;
        check_regs("R1");
        wreg = 4'd9; #1;
        chk("R1 addr", addr, 8'd9);
    endtask

    task automatic t_single_sweep;
        for (int g = 0; g < 32; g++) begin
            do_cmd(2'd0, 5'(g));
            m0 = {5'(g), 3'b000};
            m1 = {5'(g + 1), 3'b000};
            check_regs("R3");
            check_all_addr("R7");
        end
        // Group 31: r8 wraps to 0.
        wreg = 4'd8; #1;
        chk("R7 wrap", addr, 8'h00);
    endtask

    task automatic t_twin_sweep;
        for (int g = 0; g < 32; g++) begin
            do_cmd(2'd1, 5'(g));
            m0 = {5'(g), 3'b100};
            m1 = {m1[7:3], 3'b100};
            check_regs("R4");
            do_cmd(2'd2, 5'(31 - g));
            m1 = {5'(31 - g), 3'b100};
            check_regs("R5");
            check_all_addr("R8");
        end
    endtask

    task automatic t_no_effect;
        do_cmd(2'd3, 5'd7);
        check_regs("R6 op3");
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0; cmd_grp = 5'd12;
        @(negedge clk);
        cmd_op = 2'd3;
        check_regs("R6 invalid");
    endtask

    task automatic t_bus_write;
        do_wr(1'b0, 8'b10101_0_11);
        m0 = 8'b10101_0_00;
        check_regs("R2 R10 ptr0");
        do_wr(1'b1, 8'b01110_1_11);
        m1 = 8'b01110_1_00;
        check_regs("R2 R10 ptr1");
        check_all_addr("R9 single with ptr1 flag");
        do_wr(1'b0, 8'b00011_1_01);
        m0 = 8'b00011_1_00;
        check_regs("R10 ptr0 twin");
        check_all_addr("R9 twin from ptr0");
    endtask

    task automatic t_priority;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_grp = 5'd20;
        bus_wr_en = 1'b1; bus_wr_sel = 1'b0; bus_wr_data = 8'hF8;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd3; bus_wr_en = 1'b0;
        m0 = {m0[7:3], 3'b100};
        m1 = {5'd20, 3'b100};
        check_regs("R11");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_grp = 5'd1;
        bus_wr_en = 1'b1; bus_wr_sel = 1'b1; bus_wr_data = 8'h48;
        @(negedge clk);
        cmd_valid = 1'b0; bus_wr_en = 1'b0;
        m1 = 8'h48;
        check_regs("R11 op3 lets write through");
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_sweep();
        t_twin_sweep();
        t_no_effect();
        t_bus_write();
        t_priority();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m0 = '0; m1 = '0;
        check_regs("R1 second reset");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule